// File: doc/BRIEF.md
# Serial Port Transmit/Receive FIFO Pair with Threshold Requests

This block holds the data buffering for a synchronous serial port. It contains two separate FIFOs, each with its own pointers and occupancy count. The transmit FIFO is filled by the host and drained by the serial shift logic. The receive FIFO is filled by the shift logic and drained by the host. Each FIFO compares its occupancy with a programmable 4-bit threshold and raises a service request. Each request goes to a DMA request pin unconditionally. It reaches the shared interrupt line only through its own enable bit.

The two comparisons differ on purpose. The receive request asks the host to drain the FIFO once it holds more words than the threshold. The transmit request asks for a refill while the FIFO holds no more than the threshold plus one. Both comparisons use the full 5-bit count, so a completely full FIFO is handled correctly.

The port is dormant while its enable input is low. Software programs the thresholds and the interrupt enables first, then raises the enable. Clearing the enable empties both FIFOs.

Top module: `ssp_fifo_pair`

## Requirements
- R1: Words pushed into the transmit FIFO by the host leave on `line_tx_data` in push order. Words pushed into the receive FIFO by the line side leave on `host_rx_data` in push order. The two FIFOs share no storage. The read data shows the oldest entry combinationally, and the pop takes effect at the next rising edge.
- R2: `rx_dma_req` is 1 exactly when the port is enabled and `rx_count` > `rx_thresh`, where `rx_thresh` is an unsigned 4-bit value.
- R3: `tx_dma_req` is 1 exactly when the port is enabled and `tx_count` <= `tx_thresh` + 1. The sum is formed in 5 bits, so a threshold of 15 gives a limit of 16.
- R4: `irq` = (`tx_dma_req` AND `tx_irq_en`) OR (`rx_dma_req` AND `rx_irq_en`).
- R5: The DMA request outputs do not depend on the interrupt enables.
- R6: Each count (0..16) changes at the rising edge after an accepted push or pop. Full is 1 exactly when the count is 16. Empty is 1 exactly when the count is 0.
- R7: A line push into a full receive FIFO discards the word and sets `rx_overrun` at that edge. The flag stays set until a cycle with `ovr_clr` = 1 and no new overrun. A new overrun wins over a clear in the same cycle.
- R8: A pop from an empty FIFO returns data 0 and leaves the count at 0. A host push into a full transmit FIFO is discarded, and the count stays at 16.
- R9: While `port_en` = 0, both counts are forced to 0 at each edge, pushes and pops are ignored, and both requests and `irq` are 0.
- R10: A push and a pop on the same FIFO in the same cycle, when it is neither empty nor full, leave the count unchanged and keep the data order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Global port enable; low flushes both FIFOs |
| tx_thresh | input | 4 | Transmit refill threshold |
| rx_thresh | input | 4 | Receive drain threshold |
| tx_irq_en | input | 1 | Transmit request to interrupt enable |
| rx_irq_en | input | 1 | Receive request to interrupt enable |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| host_tx_push | input | 1 | Host writes a transmit word |
| host_tx_data | input | 32 | Transmit word, right-justified |
| host_rx_pop | input | 1 | Host reads a receive word |
| host_rx_data | output | 32 | Oldest receive word, 0 when empty |
| line_tx_pop | input | 1 | Shifter takes a transmit word |
| line_tx_data | output | 32 | Oldest transmit word, 0 when empty |
| line_rx_push | input | 1 | Shifter delivers a receive word |
| line_rx_data | input | 32 | Received word, right-justified |
| tx_count | output | 5 | Transmit occupancy |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_count | output | 5 | Receive occupancy |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_dma_req | output | 1 | Transmit service request |
| rx_dma_req | output | 1 | Receive service request |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Two groups of events can fall in the same cycle: a push together with a pop on one FIFO, and a new receive overrun together with a flag clear. The bench provokes the first by holding a transmit FIFO at three entries and asserting both strobes before a single edge. It then judges the outcome from the unchanged count and from the order of the popped words. It provokes the second by pushing into a full receive FIFO in the same cycle as `ovr_clr`, and expects the flag to remain set. Each request is also swept across all sixteen thresholds at every occupancy from 0 to 16, and is compared with a comparison computed in the bench.

// File: rtl/ssp_fifo_pair.sv
module ssp_fifo_pair #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [THR_W-1:0] tx_thresh,
  input  logic [THR_W-1:0] rx_thresh,
  input  logic             tx_irq_en,
  input  logic             rx_irq_en,
  input  logic             ovr_clr,
  input  logic             host_tx_push,
  input  logic [WIDTH-1:0] host_tx_data,
  input  logic             host_rx_pop,
  output logic [WIDTH-1:0] host_rx_data,
  input  logic             line_tx_pop,
  output logic [WIDTH-1:0] line_tx_data,
  input  logic             line_rx_push,
  input  logic [WIDTH-1:0] line_rx_data,
  output logic [$clog2(DEPTH):0] tx_count,
  output logic             tx_full,
  output logic             tx_empty,
  output logic [$clog2(DEPTH):0] rx_count,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             rx_overrun,
  output logic             tx_dma_req,
  output logic             rx_dma_req,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;

  logic tx_push, tx_pop, rx_push, rx_pop, rx_ovr_evt;
  assign tx_full  = (tx_count == CW'(DEPTH));
  assign tx_empty = (tx_count == '0);
  assign rx_full  = (rx_count == CW'(DEPTH));
  assign rx_empty = (rx_count == '0);

  assign tx_push    = port_en && host_tx_push && !tx_full;
  assign tx_pop     = port_en && line_tx_pop  && !tx_empty;
  assign rx_push    = port_en && line_rx_push && !rx_full;
  assign rx_pop     = port_en && host_rx_pop  && !rx_empty;
  assign rx_ovr_evt = port_en && line_rx_push && rx_full;

  assign line_tx_data = tx_empty ? '0 : tx_mem[tx_rp];
  assign host_rx_data = rx_empty ? '0 : rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= host_tx_data;
    if (rx_push) rx_mem[rx_wp] <= line_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else if (!port_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_count <= tx_count + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else if (!port_en) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_count <= rx_count + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_overrun <= 1'b0;
    else if (rx_ovr_evt) rx_overrun <= 1'b1;
    else if (ovr_clr)    rx_overrun <= 1'b0;
  end

  logic [CW-1:0] tx_limit;
  assign tx_limit   = CW'(tx_thresh) + CW'(1);
  assign tx_dma_req = port_en && (tx_count <= tx_limit);
  assign rx_dma_req = port_en && (rx_count > CW'(rx_thresh));
  assign irq = (tx_dma_req && tx_irq_en) || (rx_dma_req && rx_irq_en);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH));
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && line_rx_push && rx_full) |=> (rx_overrun && rx_full));
  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (tx_empty && rx_empty));
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_empty && host_rx_pop && !line_rx_push) |=> rx_empty);
  // R10
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && host_tx_push && line_tx_pop && !tx_full && !tx_empty)
      |=> $stable(tx_count));
  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((tx_irq_en && tx_dma_req) || (rx_irq_en && rx_dma_req)));
endmodule

// File: tb/ssp_fifo_pair_test.sv
module ssp_fifo_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0;
  logic [3:0] tx_thresh = '0, rx_thresh = '0;
  logic tx_irq_en = 1'b0, rx_irq_en = 1'b0, ovr_clr = 1'b0;
  logic host_tx_push = 1'b0, host_rx_pop = 1'b0;
  logic line_tx_pop = 1'b0, line_rx_push = 1'b0;
  logic [31:0] host_tx_data = '0, line_rx_data = '0;
  logic [31:0] host_rx_data, line_tx_data;
  logic [4:0] tx_count, rx_count;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
  logic tx_dma_req, rx_dma_req, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssp_fifo_pair uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] txw(int i);
    return 32'hA500_0000 + i * 32'h0001_0203;
  endfunction
  function automatic logic [31:0] rxw(int i);
    return 32'h5A00_0000 ^ (i * 32'h0103_0507);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R6 reset state
    chk("R6 reset tx_count", 32'(tx_count), 0);
    chk("R6 reset rx_count", 32'(rx_count), 0);
    chk("R6 reset empties", {30'b0, tx_empty, rx_empty}, 3);
    chk("R7 reset overrun", 32'(rx_overrun), 0);
    chk("R9 disabled requests", {29'b0, tx_dma_req, rx_dma_req, irq}, 0);

    // R9 pushes ignored while disabled
    host_tx_push = 1'b1; line_rx_push = 1'b1; tick();
    host_tx_push = 1'b0; line_rx_push = 1'b0; tick();
    chk("R9 push ignored tx", 32'(tx_count), 0);
    chk("R9 push ignored rx", 32'(rx_count), 0);

    port_en = 1'b1;
    tick();

    // R3 / R4 / R6 sweep on transmit side
    for (int c = 0; c <= 16; c++) begin
      chk("R6 tx count", 32'(tx_count), c);
      chk("R6 tx full", 32'(tx_full), 32'(c == 16));
      chk("R6 tx empty", 32'(tx_empty), 32'(c == 0));
      for (int t = 0; t < 16; t++) begin
        tx_thresh = 4'(t);
        tx_irq_en = 1'b1;
        #0.5;
        chk("R3 tx req", 32'(tx_dma_req), 32'(c <= t + 1));
        chk("R4 irq tx", 32'(irq), 32'(c <= t + 1));
        tx_irq_en = 1'b0;
        #0.5;
        chk("R5 tx dma free of en", 32'(tx_dma_req), 32'(c <= t + 1));
        chk("R4 irq masked", 32'(irq), 0);
      end
      if (c < 16) begin
        host_tx_data = txw(c); host_tx_push = 1'b1; tick(); host_tx_push = 1'b0;
      end
    end

    // R8 push on full transmit FIFO
    host_tx_data = 32'hDEAD_BEEF; host_tx_push = 1'b1; tick(); host_tx_push = 1'b0;
    chk("R8 tx full push dropped", 32'(tx_count), 16);

    // R1 transmit ordering
    for (int i = 0; i < 16; i++) begin
      chk("R1 tx order", line_tx_data, txw(i));
      line_tx_pop = 1'b1; tick(); line_tx_pop = 1'b0;
    end
    chk("R6 tx drained", 32'(tx_count), 0);

    // R8 pop empty
    chk("R8 tx empty data", line_tx_data, 0);
    line_tx_pop = 1'b1; host_rx_pop = 1'b1; tick(); line_tx_pop = 1'b0; host_rx_pop = 1'b0;
    chk("R8 tx empty pop count", 32'(tx_count), 0);
    chk("R8 rx empty pop count", 32'(rx_count), 0);
    chk("R8 rx empty data", host_rx_data, 0);

    // R2 / R4 / R5 sweep on receive side
    for (int c = 0; c <= 16; c++) begin
      chk("R6 rx count", 32'(rx_count), c);
      chk("R6 rx full", 32'(rx_full), 32'(c == 16));
      for (int t = 0; t < 16; t++) begin
        rx_thresh = 4'(t);
        rx_irq_en = 1'b1;
        #0.5;
        chk("R2 rx req", 32'(rx_dma_req), 32'(c > t));
        chk("R4 irq rx", 32'(irq), 32'(c > t));
        rx_irq_en = 1'b0;
        #0.5;
        chk("R5 rx dma free of en", 32'(rx_dma_req), 32'(c > t));
      end
      if (c < 16) begin
        line_rx_data = rxw(c); line_rx_push = 1'b1; tick(); line_rx_push = 1'b0;
      end
    end

    // R7 overrun on full receive FIFO
    chk("R7 no overrun yet", 32'(rx_overrun), 0);
    line_rx_data = 32'hBAD0_BAD0; line_rx_push = 1'b1; tick(); line_rx_push = 1'b0;
    chk("R7 overrun set", 32'(rx_overrun), 1);
    chk("R7 count held", 32'(rx_count), 16);
    tick();
    chk("R7 overrun sticky", 32'(rx_overrun), 1);
    // R7 set wins over clear in same cycle
    line_rx_push = 1'b1; ovr_clr = 1'b1; tick(); line_rx_push = 1'b0; ovr_clr = 1'b0;
    chk("R7 set beats clear", 32'(rx_overrun), 1);
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    chk("R7 cleared", 32'(rx_overrun), 0);

    // R1 receive ordering, discarded word absent
    for (int i = 0; i < 16; i++) begin
      chk("R1 rx order", host_rx_data, rxw(i));
      host_rx_pop = 1'b1; tick(); host_rx_pop = 1'b0;
    end
    chk("R1 rx drained", 32'(rx_count), 0);

    // R10 simultaneous push and pop
    for (int i = 0; i < 3; i++) begin
      host_tx_data = txw(100 + i); host_tx_push = 1'b1; tick();
    end
    host_tx_push = 1'b0;
    chk("R10 tx preload", 32'(tx_count), 3);
    host_tx_data = txw(103); host_tx_push = 1'b1; line_tx_pop = 1'b1; tick();
    host_tx_push = 1'b0; line_tx_pop = 1'b0;
    chk("R10 count unchanged", 32'(tx_count), 3);
    for (int i = 1; i <= 3; i++) begin
      chk("R10 order kept", line_tx_data, txw(100 + i));
      line_tx_pop = 1'b1; tick(); line_tx_pop = 1'b0;
    end

    // R9 flush on disable
    host_tx_data = txw(7); host_tx_push = 1'b1;
    line_rx_data = rxw(7); line_rx_push = 1'b1; tick();
    host_tx_push = 1'b0; line_rx_push = 1'b0;
    tx_irq_en = 1'b1; rx_irq_en = 1'b1; rx_thresh = 4'd0;
    chk("R9 pre-flush rx", 32'(rx_count), 1);
    port_en = 1'b0;
    #0.5;
    chk("R9 requests drop", {29'b0, tx_dma_req, rx_dma_req, irq}, 0);
    tick();
    chk("R9 flushed tx", 32'(tx_count), 0);
    chk("R9 flushed rx", 32'(rx_count), 0);
    port_en = 1'b1; tick();
    chk("R9 empty after re-enable", host_rx_data, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule